// File: doc/BRIEF.md
# Swizzled Buffer Address Generator

This block turns one lane's buffer-access operands into a byte address and a range-violation flag. A resource descriptor supplies a base address, a record stride, a record count, a swizzle switch and two small codes that pick the swizzle granularity. The lane supplies a record index and a byte offset. The instruction adds an immediate offset, and a scalar offset shrinks the usable range.

With swizzle off, records are laid out linearly. With swizzle on, the index is split into a high part and a low part at the index-stride boundary, and the offset is split at the element-size boundary. The parts are then interleaved so that neighbouring lanes touch neighbouring elements. Both granularities are powers of two, so every split is a shift or a mask and no divider is used.

The block is a two-stage pipeline. The first stage splits the operands and forms the products, then registers them. The second stage forms the sums and the range check, then registers the outputs. A result leaves with `valid_out` two clock edges after its operands entered with `valid_in`.

Top module: `buf_addr_gen`

## Requirements
- R1: The lane byte offset is the lane offset plus the zero-extended immediate offset, with no truncation.
- R2: With swizzle off (`swz_en`=0), the buffer offset is byte offset + stride × index, and `addr_out` is `base_addr` plus that buffer offset, modulo 2^48.
- R3: The index stride is 8 << `idx_stride_code`, giving 8, 16, 32 or 64 for codes 0 to 3.
- R4: The element size is 2 << `elem_size_code`, giving 2, 4, 8 or 16 bytes for codes 0 to 3.
- R5: With swizzle on (`swz_en`=1), the buffer offset is (⌊idx/IS⌋·stride + ⌊off/ES⌋·ES)·IS + (idx mod IS)·ES + (off mod ES), modulo 2^48, where IS is the index stride and ES is the element size.
- R6: When swizzle is off, or the stride is zero, `oob_out` is 1 exactly when the buffer offset is greater than or equal to `num_records` − `scalar_offset`.
- R7: When swizzle is on and the stride is nonzero, `oob_out` is 0 whatever the other operands are.
- R8: When `scalar_offset` exceeds `num_records`, the limit saturates to zero, so every access covered by the R6 check is flagged out of bounds.
- R9: `valid_out` is high exactly two cycles after `valid_in` was high. Results stream back to back, one per cycle.
- R10: After reset, `valid_out`, `addr_out` and `oob_out` are all 0.
- R11: In a cycle where no new result emerges, `addr_out` and `oob_out` keep their previous values. Operand values presented with `valid_in` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands are valid this cycle |
| base_addr | input | 48 | Descriptor base byte address |
| stride | input | 14 | Descriptor record stride in bytes |
| num_records | input | 32 | Descriptor range in bytes |
| swz_en | input | 1 | 1 = swizzled layout, 0 = linear layout |
| idx_stride_code | input | 2 | Index-stride code (IS = 8 << code) |
| elem_size_code | input | 2 | Element-size code (ES = 2 << code) |
| lane_index | input | 32 | Per-lane record index |
| lane_offset | input | 32 | Per-lane byte offset |
| imm_offset | input | 12 | Instruction immediate byte offset |
| scalar_offset | input | 32 | Scalar offset subtracted from the range |
| valid_out | output | 1 | Result valid |
| addr_out | output | 48 | Final byte address |
| oob_out | output | 1 | Out-of-bounds flag |

## Verification
The bench builds the block with its default widths: a 48-bit address, a 14-bit stride, a 32-bit index and offset, a 12-bit immediate and a 32-bit range. At these widths a full 32-bit index times the largest stride fits below 2^48. A base near the top of the address space still reaches the wrap-around of R2. Index values far above 64 exercise the high/low split at every index stride. The lane offset plus the immediate can carry past 32 bits, and a scalar offset larger than the range reaches the saturated limit of R8. Random operands are checked against a reference that uses true division and remainder, not shifts.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int unsigned BAG_ADDR_W   = 48;
    localparam int unsigned BAG_STRIDE_W = 14;
    localparam int unsigned BAG_RANGE_W  = 32;
    localparam int unsigned BAG_IDX_W    = 32;
    localparam int unsigned BAG_OFF_W    = 32;
    localparam int unsigned BAG_IMM_W    = 12;

    // Layout mode carried from stage 1 to stage 2.
    typedef enum logic [1:0] {
        MODE_LINEAR      = 2'd0,  // linear layout, range checked
        MODE_SWZ_CHECKED = 2'd1,  // swizzled with zero stride, range checked
        MODE_SWZ_FREE    = 2'd2   // swizzled with nonzero stride, never flagged
    } bag_mode_e;

endpackage

// File: rtl/bag_split.sv
// Splits the index at the index-stride boundary and the byte offset at the
// element-size boundary, using shifts and masks only.
module bag_split #(
    parameter int unsigned IDX_W  = 32,
    parameter int unsigned OFFS_W = 33
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFFS_W-1:0] off,
    input  logic [1:0]        is_code,
    input  logic [1:0]        es_code,
    output logic [2:0]        is_sh,
    output logic [IDX_W-1:0]  idx_hi,
    output logic [IDX_W-1:0]  idx_lo_sc,
    output logic [OFFS_W-1:0] off_hi_sc,
    output logic [OFFS_W-1:0] off_lo
);

    logic [2:0]        es_sh;
    logic [IDX_W-1:0]  idx_mask;
    logic [OFFS_W-1:0] off_mask;

    always_comb begin
        is_sh     = 3'd3 + {1'b0, is_code};   // IS = 1 << is_sh
        es_sh     = 3'd1 + {1'b0, es_code};   // ES = 1 << es_sh
        idx_mask  = (IDX_W'(1) << is_sh) - IDX_W'(1);
        off_mask  = (OFFS_W'(1) << es_sh) - OFFS_W'(1);
        idx_hi    = idx >> is_sh;
        idx_lo_sc = (idx & idx_mask) << es_sh;
        off_lo    = off & off_mask;
        off_hi_sc = off & ~off_mask;          // (off / ES) * ES
    end

endmodule

// File: rtl/bag_stage1.sv
// First pipeline stage: byte offset, split, products, limit, mode.
module bag_stage1
    import bag_pkg::*;
#(
    parameter int unsigned ADDR_W   = BAG_ADDR_W,
    parameter int unsigned STRIDE_W = BAG_STRIDE_W,
    parameter int unsigned RANGE_W  = BAG_RANGE_W,
    parameter int unsigned IDX_W    = BAG_IDX_W,
    parameter int unsigned OFF_W    = BAG_OFF_W,
    parameter int unsigned IMM_W    = BAG_IMM_W,
    localparam int unsigned OFFS_W  = OFF_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [RANGE_W-1:0]  num_records,
    input  logic                swz_en,
    input  logic [1:0]          is_code,
    input  logic [1:0]          es_code,
    input  logic [IDX_W-1:0]    lane_index,
    input  logic [OFF_W-1:0]    lane_offset,
    input  logic [IMM_W-1:0]    imm_offset,
    input  logic [RANGE_W-1:0]  scalar_offset,
    output logic                s1_v,
    output bag_mode_e           s1_mode,
    output logic [ADDR_W-1:0]   s1_base,
    output logic [RANGE_W-1:0]  s1_limit,
    output logic [ADDR_W-1:0]   s1_lin_prod,
    output logic [ADDR_W-1:0]   s1_swz_prod,
    output logic [OFFS_W-1:0]   s1_off,
    output logic [OFFS_W-1:0]   s1_off_hi_sc,
    output logic [OFFS_W-1:0]   s1_off_lo,
    output logic [IDX_W-1:0]    s1_idx_lo_sc,
    output logic [2:0]          s1_is_sh
);

    logic [OFFS_W-1:0]  off_d;
    logic [2:0]         is_sh_d;
    logic [IDX_W-1:0]   idx_hi_d;
    logic [IDX_W-1:0]   idx_lo_sc_d;
    logic [OFFS_W-1:0]  off_hi_sc_d;
    logic [OFFS_W-1:0]  off_lo_d;
    logic [RANGE_W-1:0] limit_d;
    bag_mode_e          mode_d;

    always_comb begin
        off_d = OFFS_W'(lane_offset) + OFFS_W'(imm_offset);
    end

    bag_split #(
        .IDX_W  (IDX_W),
        .OFFS_W (OFFS_W)
    ) u_split (
        .idx       (lane_index),
        .off       (off_d),
        .is_code   (is_code),
        .es_code   (es_code),
        .is_sh     (is_sh_d),
        .idx_hi    (idx_hi_d),
        .idx_lo_sc (idx_lo_sc_d),
        .off_hi_sc (off_hi_sc_d),
        .off_lo    (off_lo_d)
    );

    always_comb begin
        if (!swz_en) begin
            mode_d = MODE_LINEAR;
        end else if (stride == '0) begin
            mode_d = MODE_SWZ_CHECKED;
        end else begin
            mode_d = MODE_SWZ_FREE;
        end
        limit_d = (num_records > scalar_offset) ? (num_records - scalar_offset) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
        end else begin
            s1_v <= valid_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_mode      <= MODE_LINEAR;
            s1_base      <= '0;
            s1_limit     <= '0;
            s1_lin_prod  <= '0;
            s1_swz_prod  <= '0;
            s1_off       <= '0;
            s1_off_hi_sc <= '0;
            s1_off_lo    <= '0;
            s1_idx_lo_sc <= '0;
            s1_is_sh     <= '0;
        end else if (valid_in) begin
            s1_mode      <= mode_d;
            s1_base      <= base_addr;
            s1_limit     <= limit_d;
            s1_lin_prod  <= ADDR_W'(stride) * ADDR_W'(lane_index);
            s1_swz_prod  <= ADDR_W'(stride) * ADDR_W'(idx_hi_d);
            s1_off       <= off_d;
            s1_off_hi_sc <= off_hi_sc_d;
            s1_off_lo    <= off_lo_d;
            s1_idx_lo_sc <= idx_lo_sc_d;
            s1_is_sh     <= is_sh_d;
        end
    end

    assert_s1_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v == $past(valid_in));

    assert_s1_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(s1_base) && $stable(s1_lin_prod) && $stable(s1_limit)));

endmodule

// File: rtl/bag_stage2.sv
// Second pipeline stage: sums, final address, range check.
module bag_stage2
    import bag_pkg::*;
#(
    parameter int unsigned ADDR_W  = BAG_ADDR_W,
    parameter int unsigned RANGE_W = BAG_RANGE_W,
    parameter int unsigned IDX_W   = BAG_IDX_W,
    parameter int unsigned OFFS_W  = BAG_OFF_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_v,
    input  bag_mode_e          s1_mode,
    input  logic [ADDR_W-1:0]  s1_base,
    input  logic [RANGE_W-1:0] s1_limit,
    input  logic [ADDR_W-1:0]  s1_lin_prod,
    input  logic [ADDR_W-1:0]  s1_swz_prod,
    input  logic [OFFS_W-1:0]  s1_off,
    input  logic [OFFS_W-1:0]  s1_off_hi_sc,
    input  logic [OFFS_W-1:0]  s1_off_lo,
    input  logic [IDX_W-1:0]   s1_idx_lo_sc,
    input  logic [2:0]         s1_is_sh,
    output logic               valid_out,
    output logic [ADDR_W-1:0]  addr_out,
    output logic               oob_out
);

    logic [ADDR_W-1:0] lin_boff;
    logic [ADDR_W-1:0] swz_boff;
    logic [ADDR_W-1:0] boff;
    logic              oob_d;

    always_comb begin
        lin_boff = ADDR_W'(s1_off) + s1_lin_prod;
        swz_boff = ((s1_swz_prod + ADDR_W'(s1_off_hi_sc)) << s1_is_sh)
                 + ADDR_W'(s1_idx_lo_sc) + ADDR_W'(s1_off_lo);
        unique case (s1_mode)
            MODE_LINEAR: begin
                boff  = lin_boff;
                oob_d = (lin_boff >= ADDR_W'(s1_limit));
            end
            MODE_SWZ_CHECKED: begin
                boff  = swz_boff;
                oob_d = (swz_boff >= ADDR_W'(s1_limit));
            end
            default: begin
                boff  = swz_boff;
                oob_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            addr_out  <= '0;
            oob_out   <= 1'b0;
        end else begin
            valid_out <= s1_v;
            if (s1_v) begin
                addr_out <= s1_base + boff;
                oob_out  <= oob_d;
            end
        end
    end

    assert_out_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == $past(s1_v));

    assert_swz_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_mode == MODE_SWZ_FREE) |=> !oob_out);

    assert_sat_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_mode != MODE_SWZ_FREE && s1_limit == '0) |=> oob_out);

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_v |=> ($stable(addr_out) && $stable(oob_out)));

endmodule

// File: rtl/buf_addr_gen.sv
module buf_addr_gen
    import bag_pkg::*;
#(
    parameter int unsigned ADDR_W   = BAG_ADDR_W,
    parameter int unsigned STRIDE_W = BAG_STRIDE_W,
    parameter int unsigned RANGE_W  = BAG_RANGE_W,
    parameter int unsigned IDX_W    = BAG_IDX_W,
    parameter int unsigned OFF_W    = BAG_OFF_W,
    parameter int unsigned IMM_W    = BAG_IMM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [RANGE_W-1:0]  num_records,
    input  logic                swz_en,
    input  logic [1:0]          idx_stride_code,
    input  logic [1:0]          elem_size_code,
    input  logic [IDX_W-1:0]    lane_index,
    input  logic [OFF_W-1:0]    lane_offset,
    input  logic [IMM_W-1:0]    imm_offset,
    input  logic [RANGE_W-1:0]  scalar_offset,
    output logic                valid_out,
    output logic [ADDR_W-1:0]   addr_out,
    output logic                oob_out
);

    localparam int unsigned OFFS_W = OFF_W + 1;

    logic               s1_v;
    bag_mode_e          s1_mode;
    logic [ADDR_W-1:0]  s1_base;
    logic [RANGE_W-1:0] s1_limit;
    logic [ADDR_W-1:0]  s1_lin_prod;
    logic [ADDR_W-1:0]  s1_swz_prod;
    logic [OFFS_W-1:0]  s1_off;
    logic [OFFS_W-1:0]  s1_off_hi_sc;
    logic [OFFS_W-1:0]  s1_off_lo;
    logic [IDX_W-1:0]   s1_idx_lo_sc;
    logic [2:0]         s1_is_sh;

    bag_stage1 #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .RANGE_W  (RANGE_W),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W),
        .IMM_W    (IMM_W)
    ) u_stage1 (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_in      (valid_in),
        .base_addr     (base_addr),
        .stride        (stride),
        .num_records   (num_records),
        .swz_en        (swz_en),
        .is_code       (idx_stride_code),
        .es_code       (elem_size_code),
        .lane_index    (lane_index),
        .lane_offset   (lane_offset),
        .imm_offset    (imm_offset),
        .scalar_offset (scalar_offset),
        .s1_v          (s1_v),
        .s1_mode       (s1_mode),
        .s1_base       (s1_base),
        .s1_limit      (s1_limit),
        .s1_lin_prod   (s1_lin_prod),
        .s1_swz_prod   (s1_swz_prod),
        .s1_off        (s1_off),
        .s1_off_hi_sc  (s1_off_hi_sc),
        .s1_off_lo     (s1_off_lo),
        .s1_idx_lo_sc  (s1_idx_lo_sc),
        .s1_is_sh      (s1_is_sh)
    );

    bag_stage2 #(
        .ADDR_W  (ADDR_W),
        .RANGE_W (RANGE_W),
        .IDX_W   (IDX_W),
        .OFFS_W  (OFFS_W)
    ) u_stage2 (
        .clk          (clk),
        .rst_n        (rst_n),
        .s1_v         (s1_v),
        .s1_mode      (s1_mode),
        .s1_base      (s1_base),
        .s1_limit     (s1_limit),
        .s1_lin_prod  (s1_lin_prod),
        .s1_swz_prod  (s1_swz_prod),
        .s1_off       (s1_off),
        .s1_off_hi_sc (s1_off_hi_sc),
        .s1_off_lo    (s1_off_lo),
        .s1_idx_lo_sc (s1_idx_lo_sc),
        .s1_is_sh     (s1_is_sh),
        .valid_out    (valid_out),
        .addr_out     (addr_out),
        .oob_out      (oob_out)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && !oob_out && addr_out == '0));

endmodule

// File: tb/sim_buf_addr_gen.sv
module sim_buf_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam longint unsigned MASK48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [47:0] base_addr = '0;
    logic [13:0] stride = '0;
    logic [31:0] num_records = '0;
    logic        swz_en = 1'b0;
    logic [1:0]  idx_stride_code = '0;
    logic [1:0]  elem_size_code = '0;
    logic [31:0] lane_index = '0;
    logic [31:0] lane_offset = '0;
    logic [11:0] imm_offset = '0;
    logic [31:0] scalar_offset = '0;
    logic        valid_out;
    logic [47:0] addr_out;
    logic        oob_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // expected-result history: [0] = issued last step, [1] = two steps ago
    logic        h_v [2];
    logic [47:0] h_a [2];
    logic        h_o [2];
    string       h_ta [2];
    string       h_to [2];
    logic [47:0] last_a = '0;
    logic        last_o = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buf_addr_gen u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .valid_in        (valid_in),
        .base_addr       (base_addr),
        .stride          (stride),
        .num_records     (num_records),
        .swz_en          (swz_en),
        .idx_stride_code (idx_stride_code),
        .elem_size_code  (elem_size_code),
        .lane_index      (lane_index),
        .lane_offset     (lane_offset),
        .imm_offset      (imm_offset),
        .scalar_offset   (scalar_offset),
        .valid_out       (valid_out),
        .addr_out        (addr_out),
        .oob_out         (oob_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference from the requirements, using true division and remainder.
    function automatic longint unsigned ref_boff(
        input logic [13:0] st, input logic sw, input logic [1:0] isc, input logic [1:0] esc,
        input logic [31:0] idx, input logic [31:0] voff, input logic [11:0] imm);
        longint unsigned off, istr, esz, bo;
        off = longint'(voff) + longint'(imm);                    // R1
        if (!sw) begin
            bo = off + longint'(st) * longint'(idx);             // R2
        end else begin
            istr = 64'd8 << isc;                                 // R3
            esz  = 64'd2 << esc;                                 // R4
            bo = ((longint'(idx) / istr) * longint'(st) + (off / esz) * esz) * istr
               + (longint'(idx) % istr) * esz + (off % esz);     // R5
        end
        return bo & MASK48;
    endfunction

    task automatic compare_out();
        check(valid_out === h_v[1], "R9", "valid_out", 64'(valid_out), 64'(h_v[1]));
        if (h_v[1]) begin
            check(addr_out === h_a[1], h_ta[1], "addr_out", 64'(addr_out), 64'(h_a[1]));
            check(oob_out === h_o[1], h_to[1], "oob_out", 64'(oob_out), 64'(h_o[1]));
        end else begin
            check(addr_out === last_a, "R11", "addr_out held", 64'(addr_out), 64'(last_a));
            check(oob_out === last_o, "R11", "oob_out held", 64'(oob_out), 64'(last_o));
        end
        if (h_v[1]) begin
            last_a = h_a[1];
            last_o = h_o[1];
        end
    endtask

    task automatic issue(input logic v, input logic [47:0] ba, input logic [13:0] st,
                         input logic [31:0] nr, input logic sw, input logic [1:0] isc,
                         input logic [1:0] esc, input logic [31:0] idx, input logic [31:0] voff,
                         input logic [11:0] imm, input logic [31:0] so);
        longint unsigned bo, lim;
        bit checked;
        @(negedge clk);
        compare_out();
        valid_in = v; base_addr = ba; stride = st; num_records = nr; swz_en = sw;
        idx_stride_code = isc; elem_size_code = esc; lane_index = idx;
        lane_offset = voff; imm_offset = imm; scalar_offset = so;
        bo = ref_boff(st, sw, isc, esc, idx, voff, imm);
        lim = (nr > so) ? longint'(nr - so) : 64'd0;
        checked = !sw || (st == 14'd0);
        h_v[1] = h_v[0]; h_a[1] = h_a[0]; h_o[1] = h_o[0];
        h_ta[1] = h_ta[0]; h_to[1] = h_to[0];
        h_v[0] = v;
        h_a[0] = 48'((longint'(ba) + bo) & MASK48);
        h_o[0] = checked && (bo >= lim);
        h_ta[0] = sw ? "R5" : "R2";
        h_to[0] = !checked ? "R7" : ((lim == 0) ? "R8" : "R6");
    endtask

    task automatic idle();
        issue(1'b0, 48'($urandom) << 16, 14'($urandom), $urandom, 1'($urandom), 2'($urandom),
              2'($urandom), $urandom, $urandom, 12'($urandom), $urandom);
    endtask

    initial begin
        h_v[0] = 0; h_v[1] = 0; h_a[0] = '0; h_a[1] = '0;
        h_o[0] = 0; h_o[1] = 0; h_ta[0] = ""; h_ta[1] = ""; h_to[0] = ""; h_to[1] = "";
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(valid_out === 1'b0, "R10", "valid_out after reset", 64'(valid_out), 0);
        check(addr_out === '0, "R10", "addr_out after reset", 64'(addr_out), 0);
        check(oob_out === 1'b0, "R10", "oob_out after reset", 64'(oob_out), 0);
        rst_n = 1'b1;

        // R1: immediate added to lane offset, carry past 32 bits
        issue(1, 48'h1000, 14'd0, 32'hFFFF_FFFF, 0, 0, 0, 32'd0, 32'd100, 12'd20, 32'd0);
        issue(1, 48'h0, 14'd0, 32'hFFFF_FFFF, 0, 0, 0, 32'd5, 32'hFFFF_FFF0, 12'hFFF, 32'd0);
        // R6: boundary of the range check, linear
        issue(1, 48'h2000, 14'd4, 32'd41, 0, 0, 0, 32'd10, 32'd0, 12'd0, 32'd0);
        issue(1, 48'h2000, 14'd4, 32'd40, 0, 0, 0, 32'd10, 32'd0, 12'd0, 32'd0);
        issue(1, 48'h2000, 14'd4, 32'd50, 0, 0, 0, 32'd10, 32'd0, 12'd0, 32'd10);
        issue(1, 48'h2000, 14'd4, 32'd51, 0, 0, 0, 32'd10, 32'd0, 12'd0, 32'd10);
        // R8: scalar offset larger than range
        issue(1, 48'h3000, 14'd4, 32'd50, 0, 0, 0, 32'd0, 32'd0, 12'd0, 32'd100);
        issue(1, 48'h3000, 14'd0, 32'd50, 1, 1, 1, 32'd0, 32'd0, 12'd0, 32'd51);
        // R3, R4: all index-stride and element-size codes, swizzled
        for (int c = 0; c < 16; c++) begin
            issue(1, 48'h10_0000, 14'd16, 32'd0, 1, 2'(c >> 2), 2'(c), 32'd77, 32'd37,
                  12'd3, 32'd0);
        end
        // R7: swizzled with nonzero stride never flagged, even with zero range
        issue(1, 48'h0, 14'd3, 32'd0, 1, 3, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 12'hFFF, 32'd5);
        // R6: swizzled with zero stride is range checked
        issue(1, 48'h0, 14'd0, 32'd20, 1, 0, 1, 32'd3, 32'd7, 12'd0, 32'd0);
        issue(1, 48'h0, 14'd0, 32'd100, 1, 0, 1, 32'd3, 32'd7, 12'd0, 32'd0);
        // R2: address wraps modulo 2^48
        issue(1, 48'hFFFF_FFFF_FF00, 14'd0, 32'hFFFF_FFFF, 0, 0, 0, 32'd0, 32'h200, 12'd0, 32'd0);
        // R11: idle cycles with random operands leave outputs unchanged
        repeat (4) idle();

        // random mix (R2, R5, R6, R7, R8, R9, R11)
        for (int i = 0; i < 600; i++) begin
            logic [13:0] st;
            logic [31:0] idx, nr, so;
            st  = ($urandom % 4 == 0) ? 14'd0 : 14'($urandom);
            idx = ($urandom % 2 == 0) ? ($urandom % 512) : $urandom;
            nr  = ($urandom % 2 == 0) ? ($urandom % 65536) : $urandom;
            so  = ($urandom % 3 == 0) ? $urandom : ($urandom % 64);
            if ($urandom % 5 == 0) begin
                idle();
            end else begin
                issue(1, 48'($urandom) << ($urandom % 17), st, nr, 1'($urandom), 2'($urandom),
                      2'($urandom), idx, ($urandom % 2 == 0) ? ($urandom % 4096) : $urandom,
                      12'($urandom), so);
            end
        end
        repeat (3) idle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule